// File: doc/BRIEF.md
# Serial Boot Configuration Master

This block is the master end of a one-wire serial boot link. It produces the configuration clock for an external serial configuration memory. It holds that memory's address counter in reset through an active-low INIT line. It counts out exactly the number of clock pulses that the bitstream needs, then raises DONE, which deselects the memory. Each bit the memory presents is captured, and the bits are packed into bytes for the logic that consumes the bitstream.

A one-cycle `start_req` pulse starts a load. The pulse may come from power-up or from a reconfiguration request such as a supply glitch detector. The bit count `bit_total` and the `early_done` option are captured when the request arrives. The load then runs through these states: ST_IDLE, then ST_INIT_LOW, then ST_INIT_REL, then pairs of ST_CLK_LO and ST_CLK_HI repeated `bit_total` times, then ST_TAIL, then ST_DONE. Each state lasts a number of system clocks set by a parameter.

The transitions are as follows:
- request: any state goes to ST_INIT_LOW.
- init_expire: ST_INIT_LOW goes to ST_INIT_REL.
- setup_expire: ST_INIT_REL goes to ST_CLK_LO.
- rise: ST_CLK_LO goes to ST_CLK_HI, and a bit is sampled.
- next_bit: ST_CLK_HI goes to ST_CLK_LO while bits remain.
- last_bit: ST_CLK_HI goes to ST_TAIL once the count is reached.
- finish: ST_TAIL goes to ST_DONE.

Top module: `serial_boot_master`

## Requirements
- R1: Out of reset, the outputs are `init_n`=1, `cfg_clk`=0, `done`=0, `busy`=0, `byte_valid`=0 and `count_reached`=0.
- R2: In the cycle after `start_req` is sampled high, `init_n` goes low and stays low for exactly INIT_CYC system cycles. `cfg_clk` stays low throughout.
- R3: After INIT is released, `cfg_clk` stays low for SETUP_CYC cycles. It then toggles with low phases of LO_CYC cycles and high phases of HI_CYC cycles, always starting with a low phase.
- R4: A load gives exactly N rising edges of `cfg_clk`, where N is the value of `bit_total` when the request was taken (N ≥ 1). Changes to `bit_total` after that have no effect.
- R5: `sdata_in` is sampled at the system edge on which `cfg_clk` goes high. Bits enter `byte_out` MSB-first, so the first bit of each group of eight ends at bit 7. `byte_valid` pulses for the first cycle of the high phase that follows each eighth bit, and `byte_out` holds the byte during that pulse. A trailing partial byte is never strobed.
- R6: With `early_done`=0, `done` rises LO_CYC cycles after the final fall of `cfg_clk`. It stays high with `cfg_clk` low until the next request.
- R7: With `early_done`=1, `done` rises in the same cycle as the final rising edge of `cfg_clk`. That is one full configuration clock period earlier than in R6.
- R8: `count_reached` rises in the cycle of the Nth rising edge and stays high until the next request.
- R9: `busy` is high from the cycle after a request until the cycle before the normal `done` rise.
- R10: A request taken in any state, including mid-stream, restarts the sequence from the INIT-low phase. It clears the bit count, the byte assembly and `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | One-cycle power-up or reconfiguration request |
| bit_total | input | CNT_W | Number of bits to clock out (captured at request) |
| early_done | input | 1 | Raise DONE with the final clock rise (captured at request) |
| sdata_in | input | 1 | Serial data from the configuration memory |
| cfg_clk | output | 1 | Configuration clock to the memory |
| init_n | output | 1 | Active-low reset of the memory address counter |
| done | output | 1 | Load complete; deselects the memory |
| busy | output | 1 | Load sequence in progress |
| count_reached | output | 1 | All N bits have been sampled |
| byte_out | output | 8 | Most recently assembled byte |
| byte_valid | output | 1 | One-cycle strobe for `byte_out` |

## Verification
The checks on clock width and DONE ordering assume three things. First, `start_req` is a single-cycle pulse. Second, `bit_total` is at least one when a request is taken. Third, every phase parameter is at least one. The stimulus keeps to all three: it issues requests only at negative edges, one cycle wide, and sweeps N only over 1 to 24. The bench models the memory as an address counter. The counter is cleared while `init_n` is low, advances on each `cfg_clk` rise while `done` is low, and returns a bit computed from the address. Every expected waveform and byte is therefore derived from the phase arithmetic and that formula. Aborts are issued both inside the INIT phase and mid-stream.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_INIT_LOW = 3'd1,
        ST_INIT_REL = 3'd2,
        ST_CLK_LO   = 3'd3,
        ST_CLK_HI   = 3'd4,
        ST_TAIL     = 3'd5,
        ST_DONE     = 3'd6
    } sbm_state_e;
endpackage

// File: rtl/sbm_phase_timer.sv
module sbm_phase_timer #(
    parameter int PH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [PH_W-1:0] len,
    output logic            expire
);
    logic [PH_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remain <= '0;
        else if (load)
            remain <= len - PH_W'(1);
        else if (remain != '0)
            remain <= remain - PH_W'(1);
    end

    assign expire = (remain == '0);
endmodule

// File: rtl/sbm_bit_counter.sv
module sbm_bit_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    input  logic [CNT_W-1:0] target,
    output logic             hit
);
    logic [CNT_W-1:0] count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            hit   <= 1'b0;
        end else if (clear) begin
            count <= '0;
            hit   <= 1'b0;
        end else if (inc) begin
            count <= count + CNT_W'(1);
            if ((count + CNT_W'(1)) == target)
                hit <= 1'b1;
        end
    end
endmodule

// File: rtl/sbm_byte_shifter.sv
module sbm_byte_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] data,
    output logic         valid
);
    localparam int IDX_W = (W > 1) ? $clog2(W) : 1;

    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data  <= '0;
            idx   <= '0;
            valid <= 1'b0;
        end else if (clear) begin
            data  <= '0;
            idx   <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (shift_en) begin
                data <= {data[W-2:0], din};
                if (idx == IDX_W'(W - 1)) begin
                    idx   <= '0;
                    valid <= 1'b1;
                end else begin
                    idx <= idx + IDX_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/serial_boot_master.sv
module serial_boot_master
    import sbm_pkg::*;
#(
    parameter int INIT_CYC  = 4,
    parameter int SETUP_CYC = 2,
    parameter int LO_CYC    = 2,
    parameter int HI_CYC    = 2,
    parameter int CNT_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic [CNT_W-1:0] bit_total,
    input  logic             early_done,
    input  logic             sdata_in,
    output logic             cfg_clk,
    output logic             init_n,
    output logic             done,
    output logic             busy,
    output logic             count_reached,
    output logic [7:0]       byte_out,
    output logic             byte_valid
);
    localparam int PH_MAX_A = (INIT_CYC > SETUP_CYC) ? INIT_CYC : SETUP_CYC;
    localparam int PH_MAX_B = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
    localparam int PH_MAX   = (PH_MAX_A > PH_MAX_B) ? PH_MAX_A : PH_MAX_B;
    localparam int PH_W     = $clog2(PH_MAX + 1);

    sbm_state_e       state, state_nx;
    logic             tmr_load, tmr_expire, sample, clear;
    logic [PH_W-1:0]  tmr_len;
    logic [CNT_W-1:0] n_q;
    logic             early_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // request capture of count and mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q     <= '0;
            early_q <= 1'b0;
        end else if (start_req) begin
            n_q     <= bit_total;
            early_q <= early_done;
        end
    end

    // next state and phase control
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_len  = '0;
        sample   = 1'b0;
        clear    = 1'b0;
        if (start_req) begin
            state_nx = ST_INIT_LOW;
            tmr_load = 1'b1;
            tmr_len  = PH_W'(INIT_CYC);
            clear    = 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_INIT_LOW: if (tmr_expire) begin
                    state_nx = ST_INIT_REL;
                    tmr_load = 1'b1;
                    tmr_len  = PH_W'(SETUP_CYC);
                end
                ST_INIT_REL: if (tmr_expire) begin
                    state_nx = ST_CLK_LO;
                    tmr_load = 1'b1;
                    tmr_len  = PH_W'(LO_CYC);
                end
                ST_CLK_LO: if (tmr_expire) begin
                    state_nx = ST_CLK_HI;
                    tmr_load = 1'b1;
                    tmr_len  = PH_W'(HI_CYC);
                    sample   = 1'b1;
                end
                ST_CLK_HI: if (tmr_expire) begin
                    state_nx = count_reached ? ST_TAIL : ST_CLK_LO;
                    tmr_load = 1'b1;
                    tmr_len  = PH_W'(LO_CYC);
                end
                ST_TAIL: if (tmr_expire) state_nx = ST_DONE;
                ST_DONE: ;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        cfg_clk = (state == ST_CLK_HI);
        init_n  = (state != ST_INIT_LOW);
        busy    = (state == ST_INIT_LOW) || (state == ST_INIT_REL) ||
                  (state == ST_CLK_LO)   || (state == ST_CLK_HI)   ||
                  (state == ST_TAIL);
        done    = (state == ST_DONE) ||
                  (early_q && count_reached &&
                   ((state == ST_CLK_HI) || (state == ST_TAIL)));
    end

    sbm_phase_timer #(.PH_W(PH_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .len    (tmr_len),
        .expire (tmr_expire)
    );

    sbm_bit_counter #(.CNT_W(CNT_W)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .inc    (sample),
        .target (n_q),
        .hit    (count_reached)
    );

    sbm_byte_shifter #(.W(8)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .shift_en (sample),
        .din      (sdata_in),
        .data     (byte_out),
        .valid    (byte_valid)
    );
endmodule

// File: rtl/sbm_checker.sv
module sbm_checker #(
    parameter int HI_CYC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic start_req,
    input logic cfg_clk,
    input logic init_n,
    input logic done,
    input logic byte_valid,
    input logic count_reached
);
    logic [15:0] hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hi_run <= '0;
        else if (cfg_clk) hi_run <= hi_run + 16'd1;
        else              hi_run <= '0;
    end

    // R2
    clk_quiet_in_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !init_n |-> !cfg_clk);

    // R3
    high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cfg_clk) && !$past(start_req)) |-> (hi_run == 16'(HI_CYC)));

    // R5
    byte_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> cfg_clk);

    // R8
    reached_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_reached && !start_req) |=> count_reached);

    // R6
    done_after_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> count_reached);
endmodule

bind serial_boot_master sbm_checker #(.HI_CYC(HI_CYC)) u_sbm_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_req     (start_req),
    .cfg_clk       (cfg_clk),
    .init_n        (init_n),
    .done          (done),
    .byte_valid    (byte_valid),
    .count_reached (count_reached)
);

// File: tb/sim_serial_boot_master.sv
`timescale 1ns/1ps
module sim_serial_boot_master;
    localparam int INIT_CYC  = 4;
    localparam int SETUP_CYC = 2;
    localparam int LO_CYC    = 2;
    localparam int HI_CYC    = 2;
    localparam int CNT_W     = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 1'b0;
    logic [CNT_W-1:0] bit_total = '0;
    logic early_done = 1'b0;
    logic sdata_in;
    logic cfg_clk, init_n, done, busy, count_reached, byte_valid;
    logic [7:0] byte_out;

    int vectors = 0;
    int fails = 0;
    int seed = 0;
    logic [15:0] addr;

    always #2.5 clk = ~clk;

    serial_boot_master #(
        .INIT_CYC(INIT_CYC), .SETUP_CYC(SETUP_CYC),
        .LO_CYC(LO_CYC), .HI_CYC(HI_CYC), .CNT_W(CNT_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start_req(start_req),
        .bit_total(bit_total), .early_done(early_done), .sdata_in(sdata_in),
        .cfg_clk(cfg_clk), .init_n(init_n), .done(done), .busy(busy),
        .count_reached(count_reached), .byte_out(byte_out),
        .byte_valid(byte_valid)
    );

    function automatic logic pat(int a, int s);
        return 1'(((a * 13 + s * 7) >> 1) ^ (a >> 3));
    endfunction

    // serial memory model: address cleared by INIT, advanced by clock while selected
    always @(posedge cfg_clk or negedge init_n) begin
        if (!init_n)   addr <= '0;
        else if (!done) addr <= addr + 16'd1;
    end
    assign sdata_in = pat(int'(addr), seed);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_cfg(int n, bit early, int s, int stop_t, string tag);
        int b, p, last, early_t, rises, u, k, ph, stop;
        logic e_cfg, e_done, e_valid;
        logic [7:0] e_byte;
        logic prev_cfg;
        b = INIT_CYC + SETUP_CYC;
        p = LO_CYC + HI_CYC;
        last = b + n * p + LO_CYC;
        early_t = b + (n - 1) * p + LO_CYC + 1;
        stop = (stop_t == 0) ? last + 3 : stop_t;
        rises = 0;
        prev_cfg = 1'b0;
        seed = s;
        bit_total = CNT_W'(n);
        early_done = early;
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        bit_total = CNT_W'(n + 3);
        early_done = ~early;
        for (int t = 1; t <= stop; t++) begin
            e_cfg = 1'b0;
            e_valid = 1'b0;
            e_byte = '0;
            if (t > b) begin
                u = t - b - 1;
                k = u / p;
                ph = u % p;
                if (k < n) begin
                    e_cfg = (ph >= LO_CYC);
                    if (ph == LO_CYC && (k % 8) == 7) begin
                        e_valid = 1'b1;
                        for (int i = 0; i < 8; i++)
                            e_byte = {e_byte[6:0], pat(k - 7 + i, s)};
                    end
                end
            end
            e_done = early ? (t >= early_t) : (t > last);
            check("R2 init_n", 32'(init_n), 32'(t > INIT_CYC));
            check("R3 cfg_clk", 32'(cfg_clk), 32'(e_cfg));
            check(early ? "R7 done" : "R6 done", 32'(done), 32'(e_done));
            check("R9 busy", 32'(busy), 32'(t <= last));
            check("R8 count_reached", 32'(count_reached), 32'(t >= early_t));
            check("R5 byte_valid", 32'(byte_valid), 32'(e_valid));
            if (e_valid) check("R5 byte_out", 32'(byte_out), 32'(e_byte));
            if (cfg_clk && !prev_cfg) rises++;
            prev_cfg = cfg_clk;
            @(negedge clk);
        end
        if (stop_t == 0) check(tag, 32'(rises), 32'(n));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 init_n", 32'(init_n), 32'd1);
        check("R1 cfg_clk", 32'(cfg_clk), 32'd0);
        check("R1 done", 32'(done), 32'd0);
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 byte_valid", 32'(byte_valid), 32'd0);
        check("R1 count_reached", 32'(count_reached), 32'd0);

        // R4 sweep of bit counts, both DONE modes
        for (int n = 1; n <= 24; n++) begin
            run_cfg(n, 1'b0, n, 0, "R4 rise count");
            run_cfg(n, 1'b1, n + 40, 0, "R4 rise count early");
        end

        // R10 abort mid-stream, then abort inside INIT, each followed by a full load
        run_cfg(20, 1'b0, 3, 40, "");
        run_cfg(12, 1'b0, 9, 0, "R10 restart after mid-stream abort");
        run_cfg(16, 1'b1, 4, 2, "");
        run_cfg(17, 1'b1, 11, 0, "R10 restart after init abort");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule